// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block drives the short bus sequences an I2C master issues once a byte has moved. It produces either the acknowledge bit of a received byte or a stop condition. It does this through drive-low enables on open-drain SCL and SDA lines, and it reads the resolved line levels back. A single reloadable baud counter sets every timed phase. One baud period (TBRG) lasts `brg_reload + 1` clock cycles. The counter only starts a phase once the line it waits on has been sampled at the expected level. A slave that holds SCL low therefore stretches the sequence.

Software requests an acknowledge with `ack_req`, and `ack_data` chooses ACK (0) or NACK (1). It requests a stop with `stop_req`. The enables `ack_en` and `stop_en` are high while a sequence runs and drop by themselves when it ends. At that point the sticky `irq` flag is raised. A stop also raises the sticky `stop_seen` flag. While a sequence runs, a write to the transmit buffer is refused and raises the sticky `wcol` flag.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After reset both drive-low enables are 0, `ack_en`, `stop_en`, `irq`, `wcol`, `stop_seen` are 0 and `buf_q` is 0.
- R2: An acknowledge request from idle drives SCL low for exactly one baud period (`brg_reload+1` cycles). Throughout the sequence SDA is driven low when `ack_data`=0 (ACK) and released when `ack_data`=1 (NACK).
- R3: After SCL is released in an acknowledge, the high phase counts only once `scl_in` is sampled high. SCL stays released for max(W,1) + `brg_reload` + 1 cycles, where W is the number of cycles a slave holds SCL low.
- R4: At the end of an acknowledge, SCL is driven low again, SDA is released, `ack_en` is 0 and `irq` is 1. SCL then stays driven low while the block is idle.
- R5: A stop request drives SDA low with SCL low. SCL is released `brg_reload+2` cycles after the request: one cycle to sample SDA low, then one baud period.
- R6: During a stop, SDA is released `brg_reload+2` cycles after SCL is released, when SCL is not stretched.
- R7: When SDA is sampled high with SCL high, `stop_seen` sets on the next cycle. `brg_reload+2` cycles after the SDA release, `stop_en` is 0, `irq` is 1 and both lines are released.
- R8: A `buf_wr` while `ack_en` or `stop_en` is high sets `wcol` and leaves `buf_q` unchanged. A `buf_wr` in idle loads `buf_wdata` into `buf_q`.
- R9: When `ack_req` and `stop_req` arrive in the same idle cycle, the acknowledge runs. A request made while a sequence is active is ignored.
- R10: `irq`, `wcol` and `stop_seen` stay set until their own clear inputs (`irq_clr`, `wcol_clr`, `stop_clr`) are pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| brg_reload | input | BRG_W | Baud counter reload value |
| ack_req | input | 1 | Start an acknowledge sequence |
| stop_req | input | 1 | Start a stop sequence |
| ack_data | input | 1 | 0 = ACK, 1 = NACK |
| irq_clr | input | 1 | Clear `irq` |
| wcol_clr | input | 1 | Clear `wcol` |
| stop_clr | input | 1 | Clear `stop_seen` |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | BUF_W | Transmit buffer write data |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| ack_en | output | 1 | Acknowledge sequence active |
| stop_en | output | 1 | Stop sequence active |
| stop_seen | output | 1 | Stop condition detected (sticky) |
| irq | output | 1 | Sequence complete (sticky) |
| wcol | output | 1 | Buffer write collision (sticky) |
| buf_q | output | BUF_W | Transmit buffer contents |

## Verification
The acknowledge sequence is run with several reload values: zero, one and larger. Each is combined with an ACK or a NACK and with slave stretching of zero to four cycles. The low-phase length shows that the reload is used. The SDA level tells ACK from NACK. The released-phase length tells a counter that waits for the sampled line from one that runs freely. Stop sequences are measured phase by phase at two reload values. This separates the sample-then-count order of each phase and shows when `stop_seen` and `irq` appear.

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
  parameter int BRG_W = 8,
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRG_W-1:0] brg_reload,
  input  logic             ack_req,
  input  logic             stop_req,
  input  logic             ack_data,
  input  logic             irq_clr,
  input  logic             wcol_clr,
  input  logic             stop_clr,
  input  logic             buf_wr,
  input  logic [BUF_W-1:0] buf_wdata,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             ack_en,
  output logic             stop_en,
  output logic             stop_seen,
  output logic             irq,
  output logic             wcol,
  output logic [BUF_W-1:0] buf_q
);

  typedef enum logic [3:0] {
    S_IDLE, S_ACK_LO, S_ACK_WAIT, S_ACK_HI,
    S_STP_SDA, S_STP_LO, S_STP_WSCL, S_STP_HI, S_STP_WSDA, S_STP_END
  } st_t;

  st_t              st;
  logic [BRG_W-1:0] cnt;
  logic             ack_bit;
  logic             scl_hold;

  wire tick     = (cnt == '0);
  wire busy     = (st != S_IDLE);
  wire ack_done = (st == S_ACK_HI) && tick;
  wire stp_done = (st == S_STP_END) && tick;
  wire stp_seen = (st == S_STP_WSDA) && sda_in && scl_in;

  assign ack_en  = (st == S_ACK_LO) || (st == S_ACK_WAIT) || (st == S_ACK_HI);
  assign stop_en = busy && !ack_en;

  assign scl_drive_low = (st == S_ACK_LO) || (st == S_STP_SDA) || (st == S_STP_LO)
                         || ((st == S_IDLE) && scl_hold);
  assign sda_drive_low = (ack_en && !ack_bit) || (st == S_STP_SDA) || (st == S_STP_LO)
                         || (st == S_STP_WSCL) || (st == S_STP_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ack_bit  <= 1'b1;
      scl_hold <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ack_req) begin
            st      <= S_ACK_LO;
            cnt     <= brg_reload;
            ack_bit <= ack_data;
          end else if (stop_req) begin
            st <= S_STP_SDA;
          end
        end
        S_ACK_LO:   if (tick) st <= S_ACK_WAIT; else cnt <= cnt - 1'b1;
        S_ACK_WAIT: if (scl_in) begin st <= S_ACK_HI; cnt <= brg_reload; end
        S_ACK_HI: begin
          if (tick) begin st <= S_IDLE; scl_hold <= 1'b1; end
          else cnt <= cnt - 1'b1;
        end
        S_STP_SDA:  if (!sda_in) begin st <= S_STP_LO; cnt <= brg_reload; end
        S_STP_LO:   if (tick) st <= S_STP_WSCL; else cnt <= cnt - 1'b1;
        S_STP_WSCL: if (scl_in) begin st <= S_STP_HI; cnt <= brg_reload; end
        S_STP_HI:   if (tick) st <= S_STP_WSDA; else cnt <= cnt - 1'b1;
        S_STP_WSDA: if (stp_seen) begin st <= S_STP_END; cnt <= brg_reload; end
        S_STP_END: begin
          if (tick) begin st <= S_IDLE; scl_hold <= 1'b0; end
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      wcol      <= 1'b0;
      stop_seen <= 1'b0;
      buf_q     <= '0;
    end else begin
      if (ack_done || stp_done) irq <= 1'b1;
      else if (irq_clr)         irq <= 1'b0;
      if (buf_wr && busy)       wcol <= 1'b1;
      else if (wcol_clr)        wcol <= 1'b0;
      if (stp_seen)             stop_seen <= 1'b1;
      else if (stop_clr)        stop_seen <= 1'b0;
      if (buf_wr && !busy)      buf_q <= buf_wdata;
    end
  end

  a_r9_ack_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_en && !stop_en && ack_req && stop_req) |=> (ack_en && !stop_en));
  a_r8_wcol_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_en || stop_en) && buf_wr) |=> wcol);
  a_r8_buffer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_en || stop_en) && buf_wr) |=> $stable(buf_q));
  a_r7_stop_needs_high_lines: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> $past(scl_in && sda_in));
  a_r4_ack_end_state: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_en) |-> (irq && scl_drive_low && !sda_drive_low));
  a_r3_wait_for_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK_WAIT && !scl_in) |=> (st == S_ACK_WAIT && !scl_drive_low));
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

endmodule

// File: tb/i2c_ackstop_seq_tb_top.sv
module i2c_ackstop_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] brg_reload = '0;
  logic       ack_req = 0, stop_req = 0, ack_data = 0;
  logic       irq_clr = 0, wcol_clr = 0, stop_clr = 0;
  logic       buf_wr = 0;
  logic [7:0] buf_wdata = '0;
  logic       hold_scl = 0;
  logic       scl_drive_low, sda_drive_low, ack_en, stop_en, stop_seen, irq, wcol;
  logic [7:0] buf_q;
  wire        scl_in = ~(scl_drive_low | hold_scl);
  wire        sda_in = ~sda_drive_low;

  int n_chk = 0, n_bad = 0, cyc = 0;

  localparam int NV = 6;
  localparam int VR [NV] = '{0, 1, 3, 5, 2, 7};
  localparam int VD [NV] = '{0, 1, 0, 1, 1, 0};
  localparam int VS [NV] = '{0, 0, 2, 4, 1, 3};

  i2c_ackstop_seq #(.BRG_W(8), .BUF_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload), .ack_req(ack_req),
    .stop_req(stop_req), .ack_data(ack_data), .irq_clr(irq_clr), .wcol_clr(wcol_clr),
    .stop_clr(stop_clr), .buf_wr(buf_wr), .buf_wdata(buf_wdata), .scl_in(scl_in),
    .sda_in(sda_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .ack_en(ack_en), .stop_en(stop_en), .stop_seen(stop_seen), .irq(irq),
    .wcol(wcol), .buf_q(buf_q));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic pulse_clr_irq();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic run_ack(input int r, input bit d, input int s);
    int n, m;
    bit sda_ok;
    brg_reload = 8'(r);
    ack_data = d; ack_req = 1; hold_scl = (s > 0);
    @(negedge clk); ack_req = 0;
    n = 0; sda_ok = 1;
    while (scl_drive_low && n < 1000) begin
      if (sda_drive_low !== ~d) sda_ok = 0;
      n++; @(negedge clk);
    end
    chk(n == r + 1, "R2 scl low cycles", n, r + 1);
    chk(sda_ok, "R2 sda level", sda_drive_low, ~d);
    m = 0;
    while (!scl_drive_low && m < 1000) begin
      m++;
      if (m == s) hold_scl = 0;
      @(negedge clk);
    end
    chk(m == ((s > 1) ? s : 1) + r + 1, "R3 scl released cycles", m, ((s > 1) ? s : 1) + r + 1);
    chk(irq && !ack_en && scl_drive_low && !sda_drive_low, "R4 ack end",
        {irq, ack_en, scl_drive_low, sda_drive_low}, 4'b1010);
  endtask

  task automatic run_stop(input int r);
    int n;
    brg_reload = 8'(r);
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk(stop_en && sda_drive_low && scl_drive_low, "R5 stop start",
        {stop_en, sda_drive_low, scl_drive_low}, 3'b111);
    n = 0;
    while (scl_drive_low && n < 1000) begin n++; @(negedge clk); end
    chk(n == r + 2, "R5 scl low before release", n, r + 2);
    n = 0;
    while (sda_drive_low && n < 1000) begin n++; @(negedge clk); end
    chk(n == r + 2, "R6 sda hold after scl release", n, r + 2);
    chk(!stop_seen, "R7 stop_seen not yet", stop_seen, 0);
    @(negedge clk);
    chk(stop_seen, "R7 stop_seen next cycle", stop_seen, 1);
    n = 1;
    while (!irq && n < 1000) begin n++; @(negedge clk); end
    chk(n == r + 2, "R7 cycles to irq", n, r + 2);
    chk(!stop_en && !scl_drive_low && !sda_drive_low, "R7 lines released",
        {stop_en, scl_drive_low, sda_drive_low}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low && !ack_en && !stop_en && !irq && !wcol
        && !stop_seen && buf_q == 0, "R1 reset state",
        {scl_drive_low, sda_drive_low, ack_en, stop_en, irq, wcol, stop_seen}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_ack(VR[i], VD[i], VS[i]);
      pulse_clr_irq();
    end

    run_stop(0);
    stop_clr = 1; pulse_clr_irq(); stop_clr = 0;
    run_stop(4);
    repeat (5) @(negedge clk);
    chk(irq && stop_seen, "R10 flags sticky", {irq, stop_seen}, 2'b11);
    stop_clr = 1; @(negedge clk); stop_clr = 0;
    chk(irq && !stop_seen, "R10 stop_clr clears only stop_seen", {irq, stop_seen}, 2'b10);
    pulse_clr_irq();
    chk(!irq, "R10 irq_clr", irq, 0);

    buf_wdata = 8'hA5; buf_wr = 1; @(negedge clk); buf_wr = 0;
    chk(buf_q == 8'hA5 && !wcol, "R8 idle write", buf_q, 8'hA5);
    brg_reload = 8'd3; ack_data = 0; ack_req = 1; @(negedge clk); ack_req = 0;
    buf_wdata = 8'h3C; buf_wr = 1; @(negedge clk); buf_wr = 0;
    chk(wcol && buf_q == 8'hA5, "R8 write during ack", buf_q, 8'hA5);
    while (ack_en) @(negedge clk);
    pulse_clr_irq();
    wcol_clr = 1; @(negedge clk); wcol_clr = 0;
    chk(!wcol, "R10 wcol_clr", wcol, 0);
    stop_req = 1; @(negedge clk); stop_req = 0;
    buf_wr = 1; @(negedge clk); buf_wr = 0;
    chk(wcol && buf_q == 8'hA5, "R8 write during stop", buf_q, 8'hA5);
    while (stop_en) @(negedge clk);
    pulse_clr_irq();
    wcol_clr = 1; stop_clr = 1; @(negedge clk); wcol_clr = 0; stop_clr = 0;

    brg_reload = 8'd2; ack_data = 1; ack_req = 1; stop_req = 1;
    @(negedge clk); ack_req = 0; stop_req = 0;
    chk(ack_en && !stop_en, "R9 ack wins", {ack_en, stop_en}, 2'b10);
    stop_req = 1; @(negedge clk); stop_req = 0;
    while (ack_en) @(negedge clk);
    @(negedge clk);
    chk(!stop_en && !sda_drive_low && !stop_seen, "R9 request during ack ignored",
        {stop_en, sda_drive_low, stop_seen}, 3'b000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule